// File: doc/BRIEF.md
# Multi-way translation buffer with access checking

This block translates virtual addresses for one memory access port, either the instruction-fetch side or the data side of a core. The `IS_INSTR` parameter selects which. It keeps several ways of page mappings. Four ways map small pages and one way maps large pages. A single lookup returns the physical address. If the lookup fails, it returns one exception code that covers a missing mapping, an ambiguous mapping, insufficient privilege or a forbidden access kind.

Software-style commands maintain the contents: write an entry, invalidate an entry, read an entry back, and probe an address. A command names its way in the low bits of its page operand. The entry inside that way comes from the address bits just above that way's page offset. Each command and each lookup takes one clock. Its result is registered and appears after the next rising edge. Refill from page tables is left to the surrounding logic.

Top module: `xtlb`

## Requirements
- R1: A synchronous active-high `rst` invalidates every entry and clears every registered output to zero, so a probe or lookup made right after reset finds nothing.
- R2: A write (`cmd_op`=0) targets the way given by `cmd_page[2:0]` (0..3 are the 4 KB ways, 4 is the 1 MB way). The entry index is the two page-number bits just above that way's offset, and the page tag and `cmd_word` are stored there. A read (`cmd_op`=2) returns the stored word of the indexed entry one cycle later, or zero if that entry is invalid.
- R3: A probe (`cmd_op`=3) whose address matches exactly one entry returns the address with its page offset cleared, ORed with a hit flag and the way number in bits 2:0. The hit flag is bit 4 (0x10) on the data port and bit 3 (0x08) on the instruction port.
- R4: An invalidate (`cmd_op`=1) clears the indexed entry of the selected way. A later probe of an address it covered returns zero.
- R5: A lookup that matches no entry faults with cause 24 on the data port and 16 on the instruction port.
- R6: A lookup that matches two or more entries, in the same or in different ways, faults with cause 25 (data) or 17 (instruction). No ring or attribute check is made for it. A probe that matches several entries returns zero data with `rsp_multi` set.
- R7: Bits 5:4 of an entry's word hold the ring the page requires. When the effective ring is numerically lower, the lookup faults with cause 18 for a fetch (`acc_kind`=0) and 26 for a load (1) or a store (2).
- R8: The effective ring is 0 while `acc_excm` is set, unless `acc_ring_explicit` is also set. In every other case it is `acc_ring`.
- R9: Bits 3:0 of the entry word are the attribute. When bits 3:2 are both set, every access is forbidden: load cause 28, store 29, fetch 20. Attribute 4 forbids fetch (20). An attribute with bit 1 clear forbids store (29). Any other combination is allowed, so attribute 3 permits all.
- R10: A write or invalidate whose way field is 5, 6 or 7 changes nothing, and a read with such a field returns zero.
- R11: A lookup that passes returns the entry word's page bits joined with the address offset (12 bits for ways 0..3, 20 bits for way 4). A fault returns physical address zero and reports the lookup address on `res_bad_va`.
- R12: Every command and lookup gives its registered result exactly one cycle later. A lookup or probe issued in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_op | input | 2 | 0 write, 1 invalidate, 2 read, 3 probe |
| cmd_page | input | 32 | Page operand: address bits plus way number in bits 2:0 (probe: full address) |
| cmd_word | input | 32 | Entry word for a write: physical page, ring in 5:4, attribute in 3:0 |
| rsp_valid | output | 1 | Command result valid |
| rsp_data | output | 32 | Read word or probe result |
| rsp_multi | output | 1 | Probe matched more than one entry |
| acc_valid | input | 1 | Lookup request present |
| acc_va | input | 32 | Virtual address to translate |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store |
| acc_ring | input | 2 | Current privilege ring |
| acc_excm | input | 1 | Exception-mode flag |
| acc_ring_explicit | input | 1 | Access asks for the ring field rather than the effective ring |
| res_valid | output | 1 | Lookup result valid |
| res_fault | output | 1 | Lookup faulted |
| res_cause | output | 5 | Exception code, zero when no fault |
| res_pa | output | 32 | Physical address, zero on fault |
| res_bad_va | output | 32 | Faulting virtual address, zero when no fault |

## Verification
The bench builds two instances with the default geometry: four 4 KB ways and one 1 MB way of four entries each. One instance is the data port and the other is the instruction port, and both receive the same stimulus. Every cause code and both hit-flag positions can therefore be checked against the same entry contents. The three-bit way field with only five ways also leaves codes 5 to 7 unused, which brings the ignored-selector cases within reach. A long address pool is mixed across the small and large ways, so aliasing between a 1 MB page and 4 KB pages is produced on purpose and multi-hit lookups occur in the randomised phase as well as the directed one.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_INVAL = 2'd1,
    OP_READ  = 2'd2,
    OP_PROBE = 2'd3
  } tlb_op_e;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [4:0] CAUSE_NONE       = 5'd0;
  localparam logic [4:0] CAUSE_I_MISS     = 5'd16;
  localparam logic [4:0] CAUSE_I_MULTI    = 5'd17;
  localparam logic [4:0] CAUSE_FETCH_RING = 5'd18;
  localparam logic [4:0] CAUSE_FETCH_ATTR = 5'd20;
  localparam logic [4:0] CAUSE_D_MISS     = 5'd24;
  localparam logic [4:0] CAUSE_D_MULTI    = 5'd25;
  localparam logic [4:0] CAUSE_LS_RING    = 5'd26;
  localparam logic [4:0] CAUSE_LOAD_ATTR  = 5'd28;
  localparam logic [4:0] CAUSE_STORE_ATTR = 5'd29;
endpackage

// File: rtl/xtlb_way.sv
module xtlb_way #(
  parameter int VA_W      = 32,
  parameter int WORD_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              inv_en,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  input  logic [VA_W-1:0]   a_va,
  output logic              a_hit,
  output logic [WORD_W-1:0] a_word,
  input  logic [VA_W-1:0]   b_va,
  output logic              b_hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = VA_W - PAGE_BITS;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [WORD_W-1:0]  word_q [ENTRIES];

  logic [IDX_W-1:0] ci, ai, bi;
  assign ci = cmd_va[PAGE_BITS +: IDX_W];
  assign ai = a_va[PAGE_BITS +: IDX_W];
  assign bi = b_va[PAGE_BITS +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[ci] <= 1'b1;
    end else if (inv_en) begin
      valid_q[ci] <= 1'b0;
    end
  end

  // tag and word storage carries no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[ci]  <= cmd_va[VA_W-1:PAGE_BITS];
      word_q[ci] <= wr_word;
    end
  end

  assign a_hit   = valid_q[ai] && (tag_q[ai] == a_va[VA_W-1:PAGE_BITS]);
  assign a_word  = word_q[ai];
  assign b_hit   = valid_q[bi] && (tag_q[bi] == b_va[VA_W-1:PAGE_BITS]);
  assign rd_word = valid_q[ci] ? word_q[ci] : '0;

  // R2: a write leaves its entry valid and holding the written word
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(ci)] && (word_q[$past(ci)] == $past(wr_word)));

  // R4: an invalidate leaves its entry empty
  a_r4_inval_clears: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !wr_en) |=> !valid_q[$past(ci)]);
endmodule

// File: rtl/xtlb_perm.sv
module xtlb_perm
  import xtlb_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] entry_word,
  input  logic [1:0]        eff_ring,
  input  logic [1:0]        kind,
  output logic              fault,
  output logic [4:0]        cause
);
  logic [1:0] need_ring;
  logic [3:0] attr;
  logic       locked;

  assign need_ring = entry_word[5:4];
  assign attr      = entry_word[3:0];
  assign locked    = (attr[3:2] == 2'b11);

  always_comb begin
    cause = CAUSE_NONE;
    if (eff_ring < need_ring) begin
      cause = (kind == KIND_FETCH) ? CAUSE_FETCH_RING : CAUSE_LS_RING;
    end else if (kind == KIND_FETCH) begin
      if (locked || attr == 4'd4) cause = CAUSE_FETCH_ATTR;
    end else if (kind == KIND_STORE) begin
      if (locked || !attr[1]) cause = CAUSE_STORE_ATTR;
    end else begin
      if (locked) cause = CAUSE_LOAD_ATTR;
    end
  end

  assign fault = (cause != CAUSE_NONE);
endmodule

// File: rtl/xtlb.sv
module xtlb
  import xtlb_pkg::*;
#(
  parameter bit IS_INSTR        = 1'b0,
  parameter int SMALL_WAYS      = 4,
  parameter int ENTRIES         = 4,
  parameter int SMALL_PAGE_BITS = 12,
  parameter int LARGE_PAGE_BITS = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_page,
  input  logic [31:0] cmd_word,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_multi,
  input  logic        acc_valid,
  input  logic [31:0] acc_va,
  input  logic [1:0]  acc_kind,
  input  logic [1:0]  acc_ring,
  input  logic        acc_excm,
  input  logic        acc_ring_explicit,
  output logic        res_valid,
  output logic        res_fault,
  output logic [4:0]  res_cause,
  output logic [31:0] res_pa,
  output logic [31:0] res_bad_va
);
  localparam int VA_W    = 32;
  localparam int NWAYS   = SMALL_WAYS + 1;
  localparam int SEL_W   = $clog2(NWAYS);
  localparam int HIT_BIT = IS_INSTR ? 3 : 4;
  localparam logic [4:0] MISS_CODE  = IS_INSTR ? CAUSE_I_MISS  : CAUSE_D_MISS;
  localparam logic [4:0] MULTI_CODE = IS_INSTR ? CAUSE_I_MULTI : CAUSE_D_MULTI;

  logic [SEL_W-1:0] sel;
  assign sel = cmd_page[SEL_W-1:0];

  logic [NWAYS-1:0] wr_en, inv_en, a_hit, b_hit;
  logic [31:0]      a_word  [NWAYS];
  logic [31:0]      rd_word [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    localparam int PB = (w < SMALL_WAYS) ? SMALL_PAGE_BITS : LARGE_PAGE_BITS;
    assign wr_en[w]  = cmd_valid && (cmd_op == OP_WRITE) && (sel == SEL_W'(w));
    assign inv_en[w] = cmd_valid && (cmd_op == OP_INVAL) && (sel == SEL_W'(w));
    xtlb_way #(
      .VA_W(VA_W), .WORD_W(32), .PAGE_BITS(PB), .ENTRIES(ENTRIES)
    ) u_way (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[w]), .inv_en(inv_en[w]),
      .cmd_va(cmd_page), .wr_word(cmd_word), .rd_word(rd_word[w]),
      .a_va(acc_va), .a_hit(a_hit[w]), .a_word(a_word[w]),
      .b_va(cmd_page), .b_hit(b_hit[w])
    );
  end

  // lowest matching way wins; used only when exactly one way matches
  logic [SEL_W-1:0] a_way, b_way;
  logic [31:0]      a_sel_word, a_mask, b_mask, rd_sel;
  always_comb begin
    a_way      = '0;
    b_way      = '0;
    a_sel_word = '0;
    a_mask     = (32'd1 << SMALL_PAGE_BITS) - 32'd1;
    b_mask     = (32'd1 << SMALL_PAGE_BITS) - 32'd1;
    rd_sel     = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (a_hit[w]) begin
        a_way      = SEL_W'(w);
        a_sel_word = a_word[w];
        a_mask     = (w < SMALL_WAYS) ? ((32'd1 << SMALL_PAGE_BITS) - 32'd1)
                                      : ((32'd1 << LARGE_PAGE_BITS) - 32'd1);
      end
      if (b_hit[w]) begin
        b_way  = SEL_W'(w);
        b_mask = (w < SMALL_WAYS) ? ((32'd1 << SMALL_PAGE_BITS) - 32'd1)
                                  : ((32'd1 << LARGE_PAGE_BITS) - 32'd1);
      end
      if (sel == SEL_W'(w)) rd_sel = rd_word[w];
    end
  end

  logic [$clog2(NWAYS+1)-1:0] a_cnt, b_cnt;
  assign a_cnt = $countones(a_hit);
  assign b_cnt = $countones(b_hit);

  logic [1:0] eff_ring;
  assign eff_ring = (acc_excm && !acc_ring_explicit) ? 2'd0 : acc_ring;

  logic       perm_fault;
  logic [4:0] perm_cause;
  xtlb_perm #(.WORD_W(32)) u_perm (
    .entry_word(a_sel_word), .eff_ring(eff_ring), .kind(acc_kind),
    .fault(perm_fault), .cause(perm_cause)
  );

  logic [31:0] probe_word;
  assign probe_word = (cmd_page & ~b_mask) | (32'd1 << HIT_BIT) | 32'(b_way);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_data  <= '0;
      rsp_multi <= 1'b0;
      if (cmd_valid && cmd_op == OP_READ) begin
        rsp_data <= rd_sel;
      end else if (cmd_valid && cmd_op == OP_PROBE) begin
        if (b_cnt == 1) rsp_data <= probe_word;
        rsp_multi <= (b_cnt > 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_fault  <= 1'b0;
      res_cause  <= CAUSE_NONE;
      res_pa     <= '0;
      res_bad_va <= '0;
    end else begin
      res_valid  <= acc_valid;
      res_fault  <= 1'b0;
      res_cause  <= CAUSE_NONE;
      res_pa     <= '0;
      res_bad_va <= '0;
      if (acc_valid) begin
        if (a_cnt == 0) begin
          res_fault  <= 1'b1;
          res_cause  <= MISS_CODE;
          res_bad_va <= acc_va;
        end else if (a_cnt > 1) begin
          res_fault  <= 1'b1;
          res_cause  <= MULTI_CODE;
          res_bad_va <= acc_va;
        end else if (perm_fault) begin
          res_fault  <= 1'b1;
          res_cause  <= perm_cause;
          res_bad_va <= acc_va;
        end else begin
          res_pa <= (a_sel_word & ~a_mask) | (acc_va & a_mask);
        end
      end
    end
  end

  // R1: reset empties both result registers
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !res_valid && !rsp_valid && !res_fault);

  // R5: no matching way gives the port's miss code
  a_r5_miss_code: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && a_hit == '0) |=> res_fault && res_cause == MISS_CODE);

  // R6: several matching ways give the port's multi-hit code
  a_r6_multi_code: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $countones(a_hit) > 1) |=> res_fault && res_cause == MULTI_CODE);

  // R6: a multi-hit probe carries no page data
  a_r6_probe_multi_empty: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_data == '0);

  // R8: exception mode without explicit ring acts as ring 0
  a_r8_excm_ring0: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $countones(a_hit) == 1 && acc_excm && !acc_ring_explicit &&
     a_sel_word[5:4] != 2'd0)
    |=> res_fault && (res_cause == CAUSE_FETCH_RING || res_cause == CAUSE_LS_RING));

  // R11: a fault never carries a physical address
  a_r11_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> res_valid && res_pa == '0 && res_cause != CAUSE_NONE);
endmodule

// File: tb/tb_xtlb.sv
module tb_xtlb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst = 1'b1;
  logic        c_valid = 1'b0;
  logic [1:0]  c_op = 2'd0;
  logic [31:0] c_page = '0, c_word = '0;
  logic        a_valid = 1'b0;
  logic [31:0] a_va = '0;
  logic [1:0]  a_kind = 2'd0, a_ring = 2'd0;
  logic        a_excm = 1'b0, a_expl = 1'b0;

  logic        o_rv [2];
  logic [31:0] o_rd [2];
  logic        o_rm [2];
  logic        o_av [2];
  logic        o_af [2];
  logic [4:0]  o_ac [2];
  logic [31:0] o_ap [2];
  logic [31:0] o_ab [2];

  xtlb #(.IS_INSTR(1'b0)) dut (
    .clk(clk), .rst(rst), .cmd_valid(c_valid), .cmd_op(c_op),
    .cmd_page(c_page), .cmd_word(c_word),
    .rsp_valid(o_rv[0]), .rsp_data(o_rd[0]), .rsp_multi(o_rm[0]),
    .acc_valid(a_valid), .acc_va(a_va), .acc_kind(a_kind), .acc_ring(a_ring),
    .acc_excm(a_excm), .acc_ring_explicit(a_expl),
    .res_valid(o_av[0]), .res_fault(o_af[0]), .res_cause(o_ac[0]),
    .res_pa(o_ap[0]), .res_bad_va(o_ab[0]));

  xtlb #(.IS_INSTR(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(c_valid), .cmd_op(c_op),
    .cmd_page(c_page), .cmd_word(c_word),
    .rsp_valid(o_rv[1]), .rsp_data(o_rd[1]), .rsp_multi(o_rm[1]),
    .acc_valid(a_valid), .acc_va(a_va), .acc_kind(a_kind), .acc_ring(a_ring),
    .acc_excm(a_excm), .acc_ring_explicit(a_expl),
    .res_valid(o_av[1]), .res_fault(o_af[1]), .res_cause(o_ac[1]),
    .res_pa(o_ap[1]), .res_bad_va(o_ab[1]));

  // behavioural reference: 5 ways x 4 entries, page base kept as full address
  bit          m_valid [5][4];
  logic [31:0] m_base  [5][4];
  logic [31:0] m_word  [5][4];

  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [31:0] pmask(int w);
    return (w < 4) ? 32'h0000_0FFF : 32'h000F_FFFF;
  endfunction

  function automatic int slot(int w, logic [31:0] va);
    return (w < 4) ? int'((va >> 12) & 32'd3) : int'((va >> 20) & 32'd3);
  endfunction

  function automatic void scan(input logic [31:0] va, output int cnt, output int way);
    cnt = 0;
    way = -1;
    for (int w = 0; w < 5; w++) begin
      int i;
      i = slot(w, va);
      if (m_valid[w][i] && m_base[w][i] == (va & ~pmask(w))) begin
        cnt++;
        if (way < 0) way = w;
      end
    end
  endfunction

  function automatic logic [4:0] perm(logic [31:0] word);
    logic [1:0] er;
    int at;
    er = (a_excm && !a_expl) ? 2'd0 : a_ring;
    at = int'(word[3:0]);
    if (er < word[5:4]) return (a_kind == 2'd0) ? 5'd18 : 5'd26;
    if (a_kind == 2'd0) return (at >= 12 || at == 4) ? 5'd20 : 5'd0;
    if (a_kind == 2'd2) return (at >= 12 || (at % 4) < 2) ? 5'd29 : 5'd0;
    return (at >= 12) ? 5'd28 : 5'd0;
  endfunction

  task automatic chk(string tag, string what, int p, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s port%0d %s: actual %h expected %h", tag, p, what, act, exp);
    end
  endtask

  // compute the expected registered results, step one clock, compare
  task automatic tick(string tag);
    logic        e_rv, e_rm [2], e_av, e_af [2];
    logic [31:0] e_rd [2], e_ap [2], e_ab [2];
    logic [4:0]  e_ac [2];
    int cnt, way, sel, idx;
    for (int p = 0; p < 2; p++) begin
      e_rd[p] = '0; e_rm[p] = 1'b0; e_af[p] = 1'b0;
      e_ac[p] = '0; e_ap[p] = '0;   e_ab[p] = '0;
    end
    e_rv = !rst && c_valid;
    e_av = !rst && a_valid;
    sel  = int'(c_page[2:0]);
    if (!rst && c_valid && c_op == 2'd2 && sel < 5) begin
      idx = slot(sel, c_page);
      for (int p = 0; p < 2; p++) e_rd[p] = m_valid[sel][idx] ? m_word[sel][idx] : '0;
    end
    if (!rst && c_valid && c_op == 2'd3) begin
      scan(c_page, cnt, way);
      for (int p = 0; p < 2; p++) begin
        e_rm[p] = (cnt > 1);
        if (cnt == 1)
          e_rd[p] = (c_page & ~pmask(way)) | (p == 1 ? 32'h8 : 32'h10) | 32'(way);
      end
    end
    if (!rst && a_valid) begin
      scan(a_va, cnt, way);
      for (int p = 0; p < 2; p++) begin
        if (cnt == 0)      e_ac[p] = (p == 1) ? 5'd16 : 5'd24;
        else if (cnt > 1)  e_ac[p] = (p == 1) ? 5'd17 : 5'd25;
        else               e_ac[p] = perm(m_word[way][slot(way, a_va)]);
        e_af[p] = (e_ac[p] != 0);
        if (e_af[p]) e_ab[p] = a_va;
        else e_ap[p] = (m_word[way][slot(way, a_va)] & ~pmask(way)) | (a_va & pmask(way));
      end
    end
    // reference state update after the pre-edge view is taken
    if (rst) begin
      for (int w = 0; w < 5; w++) for (int i = 0; i < 4; i++) m_valid[w][i] = 1'b0;
    end else if (c_valid && sel < 5 && (c_op == 2'd0 || c_op == 2'd1)) begin
      idx = slot(sel, c_page);
      if (c_op == 2'd0) begin
        m_valid[sel][idx] = 1'b1;
        m_base[sel][idx]  = c_page & ~pmask(sel);
        m_word[sel][idx]  = c_word;
      end else begin
        m_valid[sel][idx] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(tag, "rsp_valid", p, 32'(o_rv[p]), 32'(e_rv));
      chk(tag, "rsp_data",  p, o_rd[p], e_rd[p]);
      chk(tag, "rsp_multi", p, 32'(o_rm[p]), 32'(e_rm[p]));
      chk(tag, "res_valid", p, 32'(o_av[p]), 32'(e_av));
      chk(tag, "res_fault", p, 32'(o_af[p]), 32'(e_af[p]));
      chk(tag, "res_cause", p, 32'(o_ac[p]), 32'(e_ac[p]));
      chk(tag, "res_pa",    p, o_ap[p], e_ap[p]);
      chk(tag, "res_bad_va",p, o_ab[p], e_ab[p]);
    end
  endtask

  task automatic cmd(logic [1:0] op, logic [31:0] page, logic [31:0] word, string tag);
    c_valid = 1'b1; c_op = op; c_page = page; c_word = word; a_valid = 1'b0;
    tick(tag);
    c_valid = 1'b0;
  endtask

  task automatic acc(logic [31:0] va, logic [1:0] kind, logic [1:0] ring,
                     logic excm, logic expl, string tag);
    a_valid = 1'b1; a_va = va; a_kind = kind; a_ring = ring;
    a_excm = excm; a_expl = expl; c_valid = 1'b0;
    tick(tag);
    a_valid = 1'b0;
  endtask

  function automatic logic [31:0] pick_va();
    logic [31:0] off;
    off = 32'($urandom) & 32'h0000_3FFF;
    case ($urandom % 6)
      0: return 32'h0120_0000 | off;
      1: return 32'h0000_3000 | (off & 32'hFFF);
      2: return 32'h0123_4000 | (off & 32'hFFF);
      3: return 32'h0010_0000 | off;
      4: return 32'h0000_7000 | (off & 32'h1FFF);
      default: return 32'h0120_1000 | (off & 32'hFFF);
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL R12 watchdog expired: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) tick("R1");
    rst = 1'b0;
    tick("R1");
    cmd(2'd3, 32'h0123_4567, '0, "R1");                  // probe finds nothing
    acc(32'h0123_4567, 2'd1, 2'd0, 1'b0, 1'b0, "R1");

    cmd(2'd0, 32'h0120_0004, 32'h0400_0002, "R2");      // large way, ring 0, attr 2
    cmd(2'd2, 32'h0020_0004, '0, "R2");                  // same slot, reads 0x04000002
    cmd(2'd3, 32'h0123_4567, '0, "R3");                  // 0x01200014 / 0x0120000C
    acc(32'h0123_4567, 2'd1, 2'd0, 1'b0, 1'b0, "R11");   // pa 0x04034567
    cmd(2'd1, 32'h0020_0004, '0, "R4");
    cmd(2'd3, 32'h0123_4567, '0, "R4");
    acc(32'h0123_4567, 2'd1, 2'd0, 1'b0, 1'b0, "R5");
    acc(32'h0010_0000, 2'd0, 2'd0, 1'b0, 1'b0, "R5");

    cmd(2'd0, 32'h0120_0000, 32'h0400_0003, "R6");      // way 0
    cmd(2'd0, 32'h0120_0004, 32'h0400_0033, "R6");      // way 4, ring 3
    acc(32'h0120_0010, 2'd1, 2'd0, 1'b0, 1'b0, "R6");   // multi, not ring fault
    cmd(2'd3, 32'h0120_0010, '0, "R6");
    cmd(2'd1, 32'h0120_0000, '0, "R6");

    cmd(2'd0, 32'h0120_0004, 32'h0400_0013, "R7");      // ring 1, attr 3
    acc(32'h0120_0100, 2'd1, 2'd0, 1'b0, 1'b0, "R7");
    acc(32'h0120_0100, 2'd0, 2'd0, 1'b0, 1'b0, "R7");
    acc(32'h0120_0100, 2'd2, 2'd1, 1'b0, 1'b0, "R7");
    acc(32'h0120_0100, 2'd1, 2'd3, 1'b0, 1'b0, "R7");
    acc(32'h0120_0100, 2'd1, 2'd1, 1'b1, 1'b0, "R8");
    acc(32'h0120_0100, 2'd1, 2'd1, 1'b1, 1'b1, "R8");

    cmd(2'd0, 32'h0000_3001, 32'h0000_500C, "R9");
    acc(32'h0000_3abc, 2'd1, 2'd0, 1'b0, 1'b0, "R9");
    acc(32'h0000_3abc, 2'd2, 2'd0, 1'b0, 1'b0, "R9");
    acc(32'h0000_3abc, 2'd0, 2'd0, 1'b0, 1'b0, "R9");
    cmd(2'd0, 32'h0000_3001, 32'h0000_5001, "R9");
    acc(32'h0000_3abc, 2'd1, 2'd0, 1'b0, 1'b0, "R9");
    acc(32'h0000_3abc, 2'd2, 2'd0, 1'b0, 1'b0, "R9");
    cmd(2'd0, 32'h0000_3001, 32'h0000_5004, "R9");
    acc(32'h0000_3abc, 2'd0, 2'd0, 1'b0, 1'b0, "R9");
    acc(32'h0000_3abc, 2'd1, 2'd0, 1'b0, 1'b0, "R9");
    cmd(2'd0, 32'h0000_3001, 32'h0000_5003, "R9");
    acc(32'h0000_3abc, 2'd2, 2'd0, 1'b0, 1'b0, "R9");
    acc(32'h0000_3abc, 2'd0, 2'd0, 1'b0, 1'b0, "R11");  // pa 0x00005abc

    for (int s = 5; s < 8; s++) cmd(2'd0, 32'h0000_9000 | 32'(s), 32'h0000_0003, "R10");
    cmd(2'd2, 32'h0000_9005, '0, "R10");
    cmd(2'd1, 32'h0000_3005, '0, "R10");
    cmd(2'd3, 32'h0000_9000, '0, "R10");
    acc(32'h0000_9000, 2'd1, 2'd0, 1'b0, 1'b0, "R10");
    acc(32'h0000_3abc, 2'd1, 2'd0, 1'b0, 1'b0, "R10");  // entry survived

    // write and lookup in the same cycle: lookup sees old contents
    c_valid = 1'b1; c_op = 2'd0; c_page = 32'h0000_A002; c_word = 32'h0000_B003;
    a_valid = 1'b1; a_va = 32'h0000_A010; a_kind = 2'd1; a_ring = 2'd0;
    a_excm = 1'b0; a_expl = 1'b0;
    tick("R12");
    c_valid = 1'b0;
    tick("R12");

    for (int n = 0; n < 600; n++) begin
      c_valid = ($urandom % 3) != 0;
      c_op    = 2'($urandom);
      c_page  = pick_va() | 32'($urandom % 8);
      c_word  = 32'($urandom) & 32'hFFFF_F03F;
      a_valid = ($urandom % 4) != 0;
      a_va    = pick_va();
      a_kind  = 2'($urandom % 3);
      a_ring  = 2'($urandom);
      a_excm  = 1'($urandom);
      a_expl  = 1'($urandom);
      tick("R12");
    end
    c_valid = 1'b0;
    a_valid = 1'b0;
    tick("R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule